// File: doc/BRIEF.md
# Speculative Retirement Buffer with Deferred Faults

This block keeps instructions that have run ahead speculatively in a circular buffer until they are safe to make architecturally visible. Dispatch claims the slot at the tail in program order and returns its index. Execution units later report completion against that index, giving a result value and, when the operation went wrong, a fault flag and a cause code. Nothing about the fault leaves the block at that time. The fault is stored with the result.

Only the oldest entry can retire, and at most one entry retires per cycle. A finished, fault-free entry that is not a branch produces a register-write command. A finished branch retires with no write. A finished, faulting entry at the head raises an exception instead. The exception reports the cause and the handler address, and it empties the whole buffer. When a branch is found to be mispredicted, every entry younger than that branch is discarded in the same cycle. Any fault those entries recorded is therefore never raised. The branch and the entries older than it are kept.

Top module: `spec_retire_buf`

## Requirements
- R1: Dispatch writes the slot whose index is on `disp_idx` and then moves that index forward by one, wrapping from DEPTH-1 to 0. `disp_ready` is 0 only while DEPTH entries are in flight. A dispatch made while the buffer is full is dropped.
- R2: A completion that carries a fault causes no exception output while an older entry is still unfinished.
- R3: When the head entry is finished, fault-free and not a branch, `wr_en` is 1 in the cycle after the head reaches that state, with `wr_reg` and `wr_data` taken from the entry. Writes come out in dispatch order, at most one per cycle. `wr_reg` and `wr_data` are meaningful only while `wr_en` is 1.
- R4: A finished branch entry (dispatched with `disp_is_branch` = 1) retires without raising `wr_en`.
- R5: An unfinished head entry blocks retirement, even when younger entries have already finished.
- R6: When a faulting entry reaches the head, every older entry has already written. In the next cycle `exc_valid` pulses for one cycle with `exc_cause` set to the stored cause and `exc_pc` set to HANDLER_PC. In that same cycle the buffer is empty: `disp_idx` = 0 and `disp_ready` = 1. No flushed entry ever writes.
- R7: A mispredict at index k discards every entry younger than k in the same cycle. The next dispatch gets index k+1. Faults recorded on the discarded entries are never raised. Entry k is treated as finished and retires with no write.
- R8: A dispatch in the same cycle as a mispredict is dropped, so the next dispatch still gets index k+1.
- R9: A completion aimed at an index that is not in flight has no effect. A later instruction that takes that slot retires with its own result and raises no fault.
- R10: After reset, `disp_ready` = 1, `disp_idx` = 0, `wr_en` = 0 and `exc_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_dest | input | REG_W | Destination register of the dispatched instruction |
| disp_is_branch | input | 1 | The dispatched instruction is a branch |
| disp_ready | output | 1 | A free slot is available |
| disp_idx | output | log2(DEPTH) | Index given to the next dispatch |
| cmpl_valid | input | 1 | Completion report |
| cmpl_idx | input | log2(DEPTH) | Entry that completed |
| cmpl_value | input | DATA_W | Result value |
| cmpl_fault | input | 1 | Execution faulted |
| cmpl_cause | input | CAUSE_W | Fault cause code |
| mispred_valid | input | 1 | Branch mispredict resolved |
| mispred_idx | input | log2(DEPTH) | Entry index of the mispredicted branch |
| wr_en | output | 1 | Register-write command (registered) |
| wr_reg | output | REG_W | Register to write |
| wr_data | output | DATA_W | Value to write |
| exc_valid | output | 1 | Precise exception pulse (registered) |
| exc_cause | output | CAUSE_W | Cause of the raised fault |
| exc_pc | output | PC_W | Handler address to redirect fetch to |

## Verification
Wrong internal state in this block shows up at the ports. A wrong tail or occupancy shows on `disp_idx` and `disp_ready` in the cycle after the bad update. A stale or leftover valid or done bit shows in a later cycle, when that slot reaches the head. It appears as an extra or missing `wr_en`, or as an exception that should not happen. So a bad squash mask or a bad flush can stay hidden for many cycles, until the head catches up with the damaged slot. The bench compares every output against a reference model on every cycle. It drives long random runs with mispredicts and faults mixed in, so that damaged slots reach the head.

// File: rtl/srb_pkg.sv
package srb_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_WRITE = 2'd1,
    ACT_QUIET = 2'd2,
    ACT_TRAP  = 2'd3
  } retire_act_e;
endpackage

// File: rtl/srb_ptr_ctl.sv
module srb_ptr_ctl #(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_fire,
  input  logic             retire,
  input  logic             trap,
  input  logic             squash_valid,
  input  logic [IDX_W-1:0] squash_idx,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic             full_o
);
  logic [IDX_W-1:0] head_q, tail_q, keep_span;
  logic [CNT_W-1:0] cnt_q;

  // entries from head up to and including the branch survive a squash
  assign keep_span = squash_idx - head_q;

  always_ff @(posedge clk) begin
    if (rst || trap) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_q + IDX_W'(retire);
      if (squash_valid) begin
        tail_q <= squash_idx + IDX_W'(1);
        cnt_q  <= CNT_W'(keep_span) + CNT_W'(1) - CNT_W'(retire);
      end else begin
        tail_q <= tail_q + IDX_W'(alloc_fire);
        cnt_q  <= cnt_q + CNT_W'(alloc_fire) - CNT_W'(retire);
      end
    end
  end

  assign head_o = head_q;
  assign tail_o = tail_q;
  assign full_o = (cnt_q == CNT_W'(DEPTH));

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/srb_entry_store.sv
module srb_entry_store #(
  parameter int DEPTH   = 16,
  parameter int DATA_W  = 32,
  parameter int REG_W   = 5,
  parameter int CAUSE_W = 4,
  parameter int IDX_W   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trap,
  input  logic               alloc_fire,
  input  logic [IDX_W-1:0]   tail,
  input  logic [REG_W-1:0]   alloc_dest,
  input  logic               alloc_br,
  input  logic               cmpl_valid,
  input  logic [IDX_W-1:0]   cmpl_idx,
  input  logic [DATA_W-1:0]  cmpl_value,
  input  logic               cmpl_fault,
  input  logic [CAUSE_W-1:0] cmpl_cause,
  input  logic               squash_valid,
  input  logic [IDX_W-1:0]   squash_idx,
  input  logic [IDX_W-1:0]   head,
  input  logic               retire,
  output logic               head_valid,
  output logic               head_done,
  output logic               head_fault,
  output logic               head_br,
  output logic [REG_W-1:0]   head_dest,
  output logic [CAUSE_W-1:0] head_cause,
  output logic [DATA_W-1:0]  head_value
);
  logic [DEPTH-1:0]   vld_q, done_q, flt_q, br_q, younger;
  logic [CAUSE_W-1:0] cause_mem [DEPTH];
  logic [REG_W-1:0]   dest_mem  [DEPTH];
  logic [DATA_W-1:0]  val_mem   [DEPTH];
  logic [IDX_W-1:0]   squash_span;
  logic               cmpl_hit;

  assign squash_span = squash_idx - head;
  assign cmpl_hit    = cmpl_valid && vld_q[cmpl_idx];

  // age of each slot relative to head, compared with the branch's age
  for (genvar g = 0; g < DEPTH; g++) begin : g_age
    logic [IDX_W-1:0] age;
    assign age        = IDX_W'(g) - head;
    assign younger[g] = squash_valid && (age > squash_span);
  end

  // payload storage: one write port each, no reset
  always_ff @(posedge clk) begin
    if (cmpl_hit) begin
      val_mem[cmpl_idx]   <= cmpl_value;
      cause_mem[cmpl_idx] <= cmpl_cause;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_fire) dest_mem[tail] <= alloc_dest;
  end

  always_ff @(posedge clk) begin
    if (rst || trap) begin
      vld_q  <= '0;
      done_q <= '0;
      flt_q  <= '0;
      br_q   <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (younger[i]) begin
          vld_q[i] <= 1'b0;
        end else if (alloc_fire && tail == IDX_W'(i)) begin
          vld_q[i]  <= 1'b1;
          done_q[i] <= 1'b0;
          flt_q[i]  <= 1'b0;
          br_q[i]   <= alloc_br;
        end else begin
          if (retire && head == IDX_W'(i)) vld_q[i] <= 1'b0;
          if (cmpl_hit && cmpl_idx == IDX_W'(i)) begin
            done_q[i] <= 1'b1;
            flt_q[i]  <= cmpl_fault;
          end
          if (squash_valid && squash_idx == IDX_W'(i)) done_q[i] <= 1'b1;
        end
      end
    end
  end

  assign head_valid = vld_q[head];
  assign head_done  = done_q[head];
  assign head_fault = flt_q[head];
  assign head_br    = br_q[head];
  assign head_dest  = dest_mem[head];
  assign head_cause = cause_mem[head];
  assign head_value = val_mem[head];

  // R1: a freshly claimed slot is live and not yet finished
  p_alloc_fresh_r1: assert property (@(posedge clk) disable iff (rst)
    alloc_fire && !trap |=> vld_q[$past(tail)] && !done_q[$past(tail)]);
endmodule

// File: rtl/srb_retire.sv
module srb_retire
  import srb_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          REG_W      = 5,
  parameter int          CAUSE_W    = 4,
  parameter int          PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               head_valid,
  input  logic               head_done,
  input  logic               head_fault,
  input  logic               head_br,
  input  logic [REG_W-1:0]   head_dest,
  input  logic [CAUSE_W-1:0] head_cause,
  input  logic [DATA_W-1:0]  head_value,
  output logic               retire,
  output logic               trap,
  output logic               wr_en,
  output logic [REG_W-1:0]   wr_reg,
  output logic [DATA_W-1:0]  wr_data,
  output logic               exc_valid,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic [PC_W-1:0]    exc_pc
);
  retire_act_e act;

  always_comb begin
    if (!(head_valid && head_done)) act = ACT_IDLE;
    else if (head_fault)            act = ACT_TRAP;
    else if (head_br)               act = ACT_QUIET;
    else                            act = ACT_WRITE;
  end

  assign retire = (act == ACT_WRITE) || (act == ACT_QUIET);
  assign trap   = (act == ACT_TRAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en     <= 1'b0;
      wr_reg    <= '0;
      wr_data   <= '0;
      exc_valid <= 1'b0;
      exc_cause <= '0;
      exc_pc    <= '0;
    end else begin
      wr_en     <= (act == ACT_WRITE);
      exc_valid <= (act == ACT_TRAP);
      if (act == ACT_WRITE) begin
        wr_reg  <= head_dest;
        wr_data <= head_value;
      end
      if (act == ACT_TRAP) begin
        exc_cause <= head_cause;
        exc_pc    <= HANDLER_PC;
      end
    end
  end

  p_exc_vector_r6: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> exc_pc == HANDLER_PC);
  p_one_event_r3: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && exc_valid));
endmodule

// File: rtl/spec_retire_buf.sv
module spec_retire_buf #(
  parameter int              DEPTH      = 16,
  parameter int              DATA_W     = 32,
  parameter int              REG_W      = 5,
  parameter int              CAUSE_W    = 4,
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0100,
  localparam int             IDX_W      = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               disp_valid,
  input  logic [REG_W-1:0]   disp_dest,
  input  logic               disp_is_branch,
  output logic               disp_ready,
  output logic [IDX_W-1:0]   disp_idx,
  input  logic               cmpl_valid,
  input  logic [IDX_W-1:0]   cmpl_idx,
  input  logic [DATA_W-1:0]  cmpl_value,
  input  logic               cmpl_fault,
  input  logic [CAUSE_W-1:0] cmpl_cause,
  input  logic               mispred_valid,
  input  logic [IDX_W-1:0]   mispred_idx,
  output logic               wr_en,
  output logic [REG_W-1:0]   wr_reg,
  output logic [DATA_W-1:0]  wr_data,
  output logic               exc_valid,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic [PC_W-1:0]    exc_pc
);
  logic [IDX_W-1:0]   head, tail;
  logic               full, retire_w, trap_w, alloc_fire;
  logic               h_valid, h_done, h_fault, h_br;
  logic [REG_W-1:0]   h_dest;
  logic [CAUSE_W-1:0] h_cause;
  logic [DATA_W-1:0]  h_value;

  // flushes (exception or mispredict) win over a dispatch in the same cycle
  assign alloc_fire = disp_valid && !full && !mispred_valid && !trap_w;
  assign disp_ready = !full;
  assign disp_idx   = tail;

  srb_ptr_ctl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) ptr_i (
    .clk(clk), .rst(rst), .alloc_fire(alloc_fire), .retire(retire_w),
    .trap(trap_w), .squash_valid(mispred_valid), .squash_idx(mispred_idx),
    .head_o(head), .tail_o(tail), .full_o(full)
  );

  srb_entry_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W),
                    .CAUSE_W(CAUSE_W), .IDX_W(IDX_W)) store_i (
    .clk(clk), .rst(rst), .trap(trap_w), .alloc_fire(alloc_fire),
    .tail(tail), .alloc_dest(disp_dest), .alloc_br(disp_is_branch),
    .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx), .cmpl_value(cmpl_value),
    .cmpl_fault(cmpl_fault), .cmpl_cause(cmpl_cause),
    .squash_valid(mispred_valid), .squash_idx(mispred_idx),
    .head(head), .retire(retire_w),
    .head_valid(h_valid), .head_done(h_done), .head_fault(h_fault),
    .head_br(h_br), .head_dest(h_dest), .head_cause(h_cause),
    .head_value(h_value)
  );

  srb_retire #(.DATA_W(DATA_W), .REG_W(REG_W), .CAUSE_W(CAUSE_W),
               .PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) ret_i (
    .clk(clk), .rst(rst), .head_valid(h_valid), .head_done(h_done),
    .head_fault(h_fault), .head_br(h_br), .head_dest(h_dest),
    .head_cause(h_cause), .head_value(h_value),
    .retire(retire_w), .trap(trap_w),
    .wr_en(wr_en), .wr_reg(wr_reg), .wr_data(wr_data),
    .exc_valid(exc_valid), .exc_cause(exc_cause), .exc_pc(exc_pc)
  );

  p_trap_flushes_r6: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (disp_idx == '0) && disp_ready);
  p_mispred_tail_r8: assert property (@(posedge clk) disable iff (rst)
    mispred_valid && !trap_w |=> disp_idx == $past(mispred_idx) + IDX_W'(1));
  p_head_waits_r5: assert property (@(posedge clk) disable iff (rst)
    !(h_valid && h_done) |=> head == $past(head));
endmodule

// File: tb/spec_retire_buf_tb_top.sv
module spec_retire_buf_tb_top;
  localparam int D = 16, IW = 4, RW = 5, CW = 4, DW = 32, PW = 32;
  localparam logic [PW-1:0] HPC = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst;
  always #5 clk = ~clk;

  logic          disp_valid, disp_is_branch, disp_ready;
  logic [RW-1:0] disp_dest;
  logic [IW-1:0] disp_idx, cmpl_idx, mispred_idx;
  logic          cmpl_valid, cmpl_fault, mispred_valid;
  logic [DW-1:0] cmpl_value, wr_data;
  logic [CW-1:0] cmpl_cause, exc_cause;
  logic          wr_en, exc_valid;
  logic [RW-1:0] wr_reg;
  logic [PW-1:0] exc_pc;

  spec_retire_buf #(.DEPTH(D), .HANDLER_PC(HPC)) dut_i (
    .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_dest(disp_dest),
    .disp_is_branch(disp_is_branch), .disp_ready(disp_ready),
    .disp_idx(disp_idx), .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx),
    .cmpl_value(cmpl_value), .cmpl_fault(cmpl_fault),
    .cmpl_cause(cmpl_cause), .mispred_valid(mispred_valid),
    .mispred_idx(mispred_idx), .wr_en(wr_en), .wr_reg(wr_reg),
    .wr_data(wr_data), .exc_valid(exc_valid), .exc_cause(exc_cause),
    .exc_pc(exc_pc)
  );

  int    checks = 0, fails = 0, cyc = 0;
  bit    finished = 0;
  string tag = "R3";

  // reference model
  bit            m_vld [D], m_done [D], m_flt [D], m_br [D];
  logic [CW-1:0] m_cause [D];
  logic [RW-1:0] m_dest [D];
  logic [DW-1:0] m_val [D];
  int            m_head, m_tail, m_cnt;
  bit            e_wr, e_exc;
  logic [RW-1:0] e_reg;
  logic [DW-1:0] e_data;
  logic [CW-1:0] e_cause;

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired act=%0d exp=0", cyc);
      report();
    end
  end

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic int ring_age(int i, int h);
    return (i - h + D) % D;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < D; i++) begin
      m_vld[i] = 0; m_done[i] = 0; m_flt[i] = 0; m_br[i] = 0;
    end
    m_head = 0; m_tail = 0; m_cnt = 0;
  endtask

  task automatic model_step();
    int h, k;
    bit ret, trap, fire;
    h = m_head; ret = 0; trap = 0; e_wr = 0; e_exc = 0;
    if (m_vld[h] && m_done[h]) begin
      if (m_flt[h]) begin
        trap = 1; e_exc = 1; e_cause = m_cause[h];
      end else begin
        ret = 1;
        if (!m_br[h]) begin e_wr = 1; e_reg = m_dest[h]; e_data = m_val[h]; end
      end
    end
    fire = disp_valid && (m_cnt < D) && !mispred_valid && !trap;
    if (trap) begin model_clear(); return; end
    if (cmpl_valid && m_vld[int'(cmpl_idx)]) begin
      m_done[int'(cmpl_idx)]  = 1;
      m_flt[int'(cmpl_idx)]   = cmpl_fault;
      m_cause[int'(cmpl_idx)] = cmpl_cause;
      m_val[int'(cmpl_idx)]   = cmpl_value;
    end
    if (mispred_valid) begin
      k = int'(mispred_idx);
      m_done[k] = 1;
      for (int i = 0; i < D; i++)
        if (ring_age(i, h) > ring_age(k, h)) m_vld[i] = 0;
      m_tail = (k + 1) % D;
      m_cnt  = ring_age(k, h) + 1 - int'(ret);
    end
    if (ret) begin m_vld[h] = 0; m_head = (h + 1) % D; end
    if (!mispred_valid) begin
      if (fire) begin
        m_vld[m_tail] = 1; m_done[m_tail] = 0; m_flt[m_tail] = 0;
        m_br[m_tail] = disp_is_branch; m_dest[m_tail] = disp_dest;
        m_tail = (m_tail + 1) % D;
      end
      m_cnt = m_cnt + int'(fire) - int'(ret);
    end
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk);
    #1;
    chk(wr_en == e_wr, tag, "wr_en", 64'(wr_en), 64'(e_wr));
    if (e_wr) begin
      chk(wr_reg == e_reg, tag, "wr_reg", 64'(wr_reg), 64'(e_reg));
      chk(wr_data == e_data, tag, "wr_data", 64'(wr_data), 64'(e_data));
    end
    chk(exc_valid == e_exc, tag, "exc_valid", 64'(exc_valid), 64'(e_exc));
    if (e_exc) begin
      chk(exc_cause == e_cause, tag, "exc_cause R6", 64'(exc_cause), 64'(e_cause));
      chk(exc_pc == HPC, tag, "exc_pc R6", 64'(exc_pc), 64'(HPC));
    end
    chk(int'(disp_idx) == m_tail, tag, "disp_idx R1", 64'(disp_idx), 64'(m_tail));
    chk(disp_ready == (m_cnt < D), tag, "disp_ready R1", 64'(disp_ready), 64'(m_cnt < D));
  endtask

  task automatic idle_inputs();
    disp_valid = 0; disp_dest = '0; disp_is_branch = 0;
    cmpl_valid = 0; cmpl_idx = '0; cmpl_value = '0; cmpl_fault = 0; cmpl_cause = '0;
    mispred_valid = 0; mispred_idx = '0;
  endtask

  task automatic idle(int n);
    idle_inputs();
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic dispatch(input logic [RW-1:0] d, input bit br, output int idx);
    idle_inputs();
    idx = m_tail;
    disp_valid = 1; disp_dest = d; disp_is_branch = br;
    cycle();
    idle_inputs();
  endtask

  task automatic complete(int idx, logic [DW-1:0] v, bit f, logic [CW-1:0] c);
    idle_inputs();
    cmpl_valid = 1; cmpl_idx = IW'(idx); cmpl_value = v; cmpl_fault = f; cmpl_cause = c;
    cycle();
    idle_inputs();
  endtask

  task automatic mispredict(int idx);
    idle_inputs();
    mispred_valid = 1; mispred_idx = IW'(idx);
    cycle();
    idle_inputs();
  endtask

  task automatic finish_all();
    for (int n = 0; n < D; n++) begin
      int j;
      j = (m_head + n) % D;
      if (m_vld[j] && !m_done[j]) complete(j, $urandom, 0, '0);
    end
    idle(4);
  endtask

  task automatic rand_cycle();
    int cand [D];
    int nc, pick, nb;
    idle_inputs();
    disp_valid = ($urandom % 100) < 50;
    disp_dest = RW'($urandom);
    disp_is_branch = ($urandom % 100) < 20;
    nc = 0;
    for (int i = 0; i < D; i++) if (m_vld[i] && !m_done[i]) begin cand[nc] = i; nc++; end
    if (nc > 0 && ($urandom % 100) < 55) begin
      pick = cand[$urandom % nc];
      cmpl_valid = 1; cmpl_idx = IW'(pick); cmpl_value = $urandom;
      cmpl_fault = ($urandom % 100) < 5; cmpl_cause = CW'($urandom);
    end else if (($urandom % 100) < 3) begin
      for (int i = 0; i < D; i++) if (!m_vld[i] && !cmpl_valid) begin
        cmpl_valid = 1; cmpl_idx = IW'(i); cmpl_value = $urandom; cmpl_fault = 1; cmpl_cause = 4'hF;
      end
    end
    if (($urandom % 100) < 6) begin
      nb = 0;
      for (int i = 0; i < D; i++)
        if (m_vld[i] && !m_done[i] && m_br[i] && !(cmpl_valid && int'(cmpl_idx) == i)) begin
          cand[nb] = i; nb++;
        end
      if (nb > 0) begin mispred_valid = 1; mispred_idx = IW'(cand[$urandom % nb]); end
    end
    cycle();
  endtask

  initial begin
    int a, b, c, x, br, y, z, w, p, br2, far;
    void'($urandom(32'd4242));
    idle_inputs();
    model_clear();
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R10: reset state
    chk(disp_ready == 1, "R10", "disp_ready", 64'(disp_ready), 64'd1);
    chk(disp_idx == 0, "R10", "disp_idx", 64'(disp_idx), 64'd0);
    chk(wr_en == 0, "R10", "wr_en", 64'(wr_en), 64'd0);
    chk(exc_valid == 0, "R10", "exc_valid", 64'(exc_valid), 64'd0);

    // R3: out-of-order completion, in-order writes
    tag = "R3";
    dispatch(5'd1, 0, a); dispatch(5'd2, 0, b); dispatch(5'd3, 0, c);
    complete(c, 32'hC0DE_0003, 0, '0);
    complete(a, 32'hC0DE_0001, 0, '0);
    complete(b, 32'hC0DE_0002, 0, '0);
    idle(4);

    // R5: unfinished head blocks younger finished entry
    tag = "R5";
    dispatch(5'd4, 0, a); dispatch(5'd5, 0, b);
    complete(b, 32'h5555_0002, 0, '0);
    idle(3);
    complete(a, 32'h5555_0001, 0, '0);
    idle(3);

    // R4: branch retires quietly
    tag = "R4";
    dispatch(5'd9, 1, a);
    complete(a, 32'hBB, 0, '0);
    idle(3);

    // R2 then R6: deferred fault raised precisely
    tag = "R2";
    dispatch(5'd6, 0, a); dispatch(5'd7, 0, b); dispatch(5'd8, 0, c);
    complete(b, 32'hDEAD, 1, 4'hA);
    idle(3);
    complete(c, 32'h0C, 0, '0);
    idle(2);
    tag = "R6";
    complete(a, 32'h0A, 0, '0);
    idle(4);
    chk(disp_idx == 0, "R6", "disp_idx after flush", 64'(disp_idx), 64'd0);

    // R7: wrong-path fault discarded by mispredict
    tag = "R7";
    dispatch(5'd10, 0, x); dispatch(5'd0, 1, br);
    dispatch(5'd11, 0, y); dispatch(5'd12, 0, z);
    complete(y, 32'hBAD, 1, 4'h3);
    mispredict(br);
    dispatch(5'd13, 0, w);
    chk(w == (br + 1) % D, "R7", "index after mispredict", 64'(w), 64'((br + 1) % D));
    complete(x, 32'h1010, 0, '0);
    complete(w, 32'h1313, 0, '0);
    idle(6);

    // R8: dispatch dropped when it meets a mispredict
    tag = "R8";
    dispatch(5'd14, 0, p); dispatch(5'd0, 1, br2);
    idle_inputs();
    disp_valid = 1; disp_dest = 5'd15; mispred_valid = 1; mispred_idx = IW'(br2);
    cycle();
    idle_inputs();
    chk(int'(disp_idx) == (br2 + 1) % D, "R8", "disp_idx", 64'(disp_idx), 64'((br2 + 1) % D));
    complete(p, 32'h1414, 0, '0);
    idle(4);

    // R1: fill to full, extra dispatch dropped
    tag = "R1";
    idle_inputs();
    for (int i = 0; i < D + 2; i++) begin
      disp_valid = 1; disp_dest = RW'(i); disp_is_branch = 0;
      cycle();
    end
    idle_inputs();
    chk(disp_ready == 0, "R1", "disp_ready when full", 64'(disp_ready), 64'd0);
    finish_all();

    // R9: completion to a slot not in flight is ignored
    tag = "R9";
    dispatch(5'd20, 0, a); dispatch(5'd21, 0, b);
    far = (m_tail + 2) % D;
    complete(far, 32'hFFFF, 1, 4'hE);
    for (int i = 0; i < 4; i++) dispatch(RW'(22 + i), 0, c);
    finish_all();

    // mixed random traffic
    tag = "R3";
    for (int i = 0; i < 4000; i++) rand_cycle();
    idle_inputs();
    finish_all();

    finished = 1;
    report();
  end
endmodule